// File: doc/BRIEF.md
# Parallel-Port Enhanced Write Cycle Engine

This block sits on the host-bridge side of a parallel port. It runs byte write cycles toward a peripheral under the older enhanced-port handshake. The host opens a cycle by pulling its write strobe low. The engine then captures the byte and a data/address select. It drives the byte onto the peripheral bus and lowers the matching strobe: the data strobe for a data write, the address strobe for an address write. The cycle lasts as long as the host holds its strobe. When the host lets go, the engine raises the strobe and goes back to idle.

The peripheral can stretch the host cycle with its active-low wait line. The host ready output is pulled low only while a cycle is running and wait is low. A watchdog counts the clocks of each cycle. A cycle that outlasts a fixed 10 microsecond window is aborted, and a sticky timeout bit is set. The bit stays set until a status read or a dedicated clear input clears it.

Between cycles the port acts as a plain control port. Three general control outputs mirror their control bits. The write line and the bus output enable follow the direction bit.

Top module: `eppWrEngine`

## Requirements
- R1: After reset, both strobes are high, host ready is high, the timeout bit is 0 and the held byte is 0x00.
- R2: When the host write strobe is sampled low while idle, from the next clock the captured byte is on `pData`, `pDataOe` is 1, `writeN` is 0 and, for `regSelAddr`=0, `dataStbN` is low and `addrStbN` is high.
- R3: With `regSelAddr`=1 at the start of a cycle, `addrStbN` goes low and `dataStbN` stays high; the two strobes are never low together.
- R4: `hostRdy` is low only while a cycle is running and `waitN` is 0, and it follows `waitN` with no clock delay; `waitN` low while idle leaves `hostRdy` high.
- R5: One clock after the host write strobe is sampled high during a cycle, both strobes are high and the idle outputs return.
- R6: A cycle whose host strobe stays low for `TO_CYCLES` clocks (CLK_MHZ*TIMEOUT_NS/1000, which is 2500 by default) is aborted on the next edge. Both strobes rise, `hostRdy` goes high and the timeout bit is set. No new cycle starts until the host strobe has been released.
- R7: The timeout bit stays set until `statusRd` or `toClr` is sampled high. A timeout in the same clock wins over a clear.
- R8: While idle, `strobeOut`, `autoFdOut` and `initOut` equal `ctlStrobe`, `ctlAutoFd` and `ctlInit`, `writeN` equals `ctlDirBit`, and `pDataOe` equals the inverse of `ctlDirBit`. During a cycle the three control outputs are 0.
- R9: The byte on `pData` holds steady for the whole cycle even if `hostData` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| regSelAddr | input | 1 | 1 selects the address register, 0 the data register |
| hostData | input | DATA_W | Byte written by the host |
| ctlDirBit | input | 1 | Control-port direction bit (0 = port drives the bus) |
| ctlStrobe | input | 1 | Control bit mirrored on strobeOut when idle |
| ctlAutoFd | input | 1 | Control bit mirrored on autoFdOut when idle |
| ctlInit | input | 1 | Control bit mirrored on initOut when idle |
| waitN | input | 1 | Peripheral wait, active low |
| statusRd | input | 1 | Status read pulse, clears the timeout bit |
| toClr | input | 1 | Dedicated timeout clear |
| pData | output | DATA_W | Peripheral data bus value |
| pDataOe | output | 1 | Peripheral bus output enable |
| dataStbN | output | 1 | Data strobe, active low |
| addrStbN | output | 1 | Address strobe, active low |
| writeN | output | 1 | Write line, active low |
| hostRdy | output | 1 | Host ready, low stretches the host cycle |
| strobeOut | output | 1 | General control output |
| autoFdOut | output | 1 | General control output |
| initOut | output | 1 | General control output |
| toStatus | output | 1 | Sticky timeout status bit |

## Verification
The bench changes `hostData` in the middle of a cycle. A design that keeps sampling the input instead of holding the captured byte would show the new value on the peripheral bus. It pulls `waitN` low while idle and then inside a cycle. A ready line that is registered, or gated by wait alone, would either lag by a clock or stretch host accesses that have nothing to do with the port. The watchdog is probed one clock before and one clock after its limit, and the host keeps its strobe low after the abort. An off-by-one counter would abort early or late, and an engine that re-enters a cycle would drop a strobe again. The sticky bit is cleared once through each clear path. A missing path would leave the bit stuck at 1.

// File: rtl/eppWrPkg.sv
package eppWrPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_ABORT  = 2'd2
  } wrState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture byte and register select this clock
    logic cycleOn;  // a write cycle is driving the peripheral side
  } dpCtl_t;

endpackage

// File: rtl/eppWrCtrl.sv
module eppWrCtrl
  import eppWrPkg::*;
#(
  parameter int TO_CYCLES = 2500
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   hostWrN,
  input  logic   waitN,
  input  logic   statusRd,
  input  logic   toClr,
  output dpCtl_t dpCtl,
  output logic   hostRdy,
  output logic   toStatus
);

  localparam int CNT_W = $clog2(TO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TO_CYCLES - 1);

  wrState_t state, stateNxt;
  logic [CNT_W-1:0] wdCnt;
  logic timeoutHit;

  assign timeoutHit = (state == ST_ACTIVE) && !hostWrN && (wdCnt == CNT_LAST);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (!hostWrN) stateNxt = ST_ACTIVE;
      ST_ACTIVE: if (hostWrN) stateNxt = ST_IDLE;
                 else if (timeoutHit) stateNxt = ST_ABORT;
      ST_ABORT:  if (hostWrN) stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wdCnt    <= '0;
      toStatus <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_ACTIVE) wdCnt <= wdCnt + 1'b1;
      else                    wdCnt <= '0;
      if (timeoutHit)              toStatus <= 1'b1;
      else if (statusRd || toClr)  toStatus <= 1'b0;
    end
  end

  assign dpCtl.load    = (state == ST_IDLE) && !hostWrN;
  assign dpCtl.cycleOn = (state == ST_ACTIVE);
  assign hostRdy       = !((state == ST_ACTIVE) && !waitN);

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE) |-> (wdCnt <= CNT_LAST)); // R6
  AST_ABORT_ON_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !hostWrN && wdCnt == CNT_LAST) |=> (state == ST_ABORT && toStatus)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ABORT && !hostWrN) |=> (state == ST_ABORT)); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (toStatus && !statusRd && !toClr) |=> toStatus); // R7

endmodule

// File: rtl/eppWrData.sv
module eppWrData
  import eppWrPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              regSelAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              ctlDirBit,
  input  logic              ctlStrobe,
  input  logic              ctlAutoFd,
  input  logic              ctlInit,
  output logic [DATA_W-1:0] pData,
  output logic              pDataOe,
  output logic              dataStbN,
  output logic              addrStbN,
  output logic              writeN,
  output logic              strobeOut,
  output logic              autoFdOut,
  output logic              initOut
);

  logic [DATA_W-1:0] byteReg;
  logic selAddrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg    <= '0;
      selAddrReg <= 1'b0;
    end else if (dpCtl.load) begin
      byteReg    <= hostData;
      selAddrReg <= regSelAddr;
    end
  end

  assign pData     = byteReg;
  assign pDataOe   = dpCtl.cycleOn || !ctlDirBit;
  assign dataStbN  = !(dpCtl.cycleOn && !selAddrReg);
  assign addrStbN  = !(dpCtl.cycleOn && selAddrReg);
  assign writeN    = dpCtl.cycleOn ? 1'b0 : ctlDirBit;
  assign strobeOut = dpCtl.cycleOn ? 1'b0 : ctlStrobe;
  assign autoFdOut = dpCtl.cycleOn ? 1'b0 : ctlAutoFd;
  assign initOut   = dpCtl.cycleOn ? 1'b0 : ctlInit;

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.cycleOn && $past(dpCtl.cycleOn)) |-> $stable(pData)); // R9

endmodule

// File: rtl/eppWrEngine.sv
module eppWrEngine
  import eppWrPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CLK_MHZ    = 250,
  parameter int TIMEOUT_NS = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrN,
  input  logic              regSelAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              ctlDirBit,
  input  logic              ctlStrobe,
  input  logic              ctlAutoFd,
  input  logic              ctlInit,
  input  logic              waitN,
  input  logic              statusRd,
  input  logic              toClr,
  output logic [DATA_W-1:0] pData,
  output logic              pDataOe,
  output logic              dataStbN,
  output logic              addrStbN,
  output logic              writeN,
  output logic              hostRdy,
  output logic              strobeOut,
  output logic              autoFdOut,
  output logic              initOut,
  output logic              toStatus
);

  localparam int TO_CYCLES = CLK_MHZ * TIMEOUT_NS / 1000;

  dpCtl_t dpCtl;

  eppWrCtrl #(.TO_CYCLES(TO_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrN(hostWrN), .waitN(waitN),
    .statusRd(statusRd), .toClr(toClr), .dpCtl(dpCtl),
    .hostRdy(hostRdy), .toStatus(toStatus)
  );

  eppWrData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .regSelAddr(regSelAddr),
    .hostData(hostData), .ctlDirBit(ctlDirBit), .ctlStrobe(ctlStrobe),
    .ctlAutoFd(ctlAutoFd), .ctlInit(ctlInit), .pData(pData),
    .pDataOe(pDataOe), .dataStbN(dataStbN), .addrStbN(addrStbN),
    .writeN(writeN), .strobeOut(strobeOut), .autoFdOut(autoFdOut),
    .initOut(initOut)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~dataStbN, ~addrStbN})); // R3
  AST_RDY_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdy |-> (!waitN && (!dataStbN || !addrStbN))); // R4
  AST_END_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrN && (!dataStbN || !addrStbN)) |=> (dataStbN && addrStbN)); // R5

endmodule

// File: tb/eppWrEngine_bench.sv
module eppWrEngine_bench;

  localparam int TO_CYCLES = 2500; // 250 MHz x 10 us

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrN = 1'b1, regSelAddr = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic ctlDirBit = 1'b1, ctlStrobe = 1'b0, ctlAutoFd = 1'b0, ctlInit = 1'b0;
  logic waitN = 1'b1, statusRd = 1'b0, toClr = 1'b0;
  logic [7:0] pData;
  logic pDataOe, dataStbN, addrStbN, writeN, hostRdy;
  logic strobeOut, autoFdOut, initOut, toStatus;

  always #2 clk = ~clk;

  eppWrEngine #(.DATA_W(8), .CLK_MHZ(250), .TIMEOUT_NS(10000)) u_eppWrEngine (
    .clk(clk), .rstN(rstN), .hostWrN(hostWrN), .regSelAddr(regSelAddr),
    .hostData(hostData), .ctlDirBit(ctlDirBit), .ctlStrobe(ctlStrobe),
    .ctlAutoFd(ctlAutoFd), .ctlInit(ctlInit), .waitN(waitN),
    .statusRd(statusRd), .toClr(toClr), .pData(pData), .pDataOe(pDataOe),
    .dataStbN(dataStbN), .addrStbN(addrStbN), .writeN(writeN),
    .hostRdy(hostRdy), .strobeOut(strobeOut), .autoFdOut(autoFdOut),
    .initOut(initOut), .toStatus(toStatus)
  );

  // {pData, oe, dStb, aStb, wr, rdy, stb, afd, init, to}
  localparam logic [16:0] M_ALL  = 17'h1FFFF;
  localparam logic [16:0] M_CTRL = 17'h001FF;

  typedef struct {
    string       tag;
    logic [16:0] exp;
    logic [16:0] mask;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  function automatic logic [16:0] mk(logic [7:0] b, logic oe, logic ds, logic as,
                                     logic wr, logic rdy, logic stb, logic afd,
                                     logic ini, logic to);
    return {b, oe, ds, as, wr, rdy, stb, afd, ini, to};
  endfunction

  task automatic expectOut(string tag, logic [16:0] exp, logic [16:0] mask);
    expItem_t it;
    it.tag = tag; it.exp = exp; it.mask = mask;
    expQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  // Monitor: pops expectations and compares them with the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [16:0] act;
        it = expQ.pop_front();
        act = {pData, pDataOe, dataStbN, addrStbN, writeN, hostRdy,
               strobeOut, autoFdOut, initOut, toStatus};
        checks++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h mask=%h", it.tag, act, it.exp, it.mask);
        end
      end
    end
  end

  task automatic stepClk(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    stepClk(3);
    rstN = 1'b1;
    stepClk(1);
    expectOut("R1 reset state", mk(8'h00,0,1,1,1,1,0,0,0,0), M_ALL);

    // R8 idle passthrough
    ctlDirBit = 1'b0; ctlStrobe = 1'b1; ctlAutoFd = 1'b1; ctlInit = 1'b1;
    #1;
    expectOut("R8 idle mirror", mk(8'h00,1,1,1,0,1,1,1,1,0), M_CTRL);
    waitN = 1'b0; #1;
    expectOut("R4 wait low while idle", mk(8'h00,1,1,1,0,1,1,1,1,0), M_CTRL);
    waitN = 1'b1;

    // R2 data write
    @(negedge clk);
    hostWrN = 1'b0; regSelAddr = 1'b0; hostData = 8'hA5;
    stepClk(1);
    expectOut("R2 data cycle start", mk(8'hA5,1,0,1,0,1,0,0,0,0), M_ALL);
    hostData = 8'h3C;
    stepClk(1);
    expectOut("R9 byte held", mk(8'hA5,1,0,1,0,1,0,0,0,0), M_ALL);
    waitN = 1'b0; #1;
    expectOut("R4 ready drops with wait", mk(8'hA5,1,0,1,0,0,0,0,0,0), M_ALL);
    stepClk(3);
    expectOut("R4 ready stays low", mk(8'hA5,1,0,1,0,0,0,0,0,0), M_ALL);
    waitN = 1'b1; #1;
    expectOut("R4 ready back high", mk(8'hA5,1,0,1,0,1,0,0,0,0), M_ALL);
    hostWrN = 1'b1;
    stepClk(1);
    expectOut("R5 cycle end", mk(8'hA5,1,1,1,0,1,1,1,1,0), M_ALL);

    // R3 address write
    hostWrN = 1'b0; regSelAddr = 1'b1; hostData = 8'h5A;
    stepClk(1);
    expectOut("R3 address strobe", mk(8'h5A,1,1,0,0,1,0,0,0,0), M_ALL);
    hostWrN = 1'b1; regSelAddr = 1'b0;
    stepClk(1);
    expectOut("R5 address cycle end", mk(8'h5A,1,1,1,0,1,1,1,1,0), M_ALL);

    // R6 timeout, cleared by status read
    hostWrN = 1'b0; hostData = 8'hC3; waitN = 1'b0;
    stepClk(1);
    expectOut("R6 hung cycle started", mk(8'hC3,1,0,1,0,0,0,0,0,0), M_ALL);
    stepClk(TO_CYCLES - 1);
    expectOut("R6 still active at limit", mk(8'hC3,1,0,1,0,0,0,0,0,0), M_ALL);
    stepClk(1);
    expectOut("R6 aborted", mk(8'hC3,1,1,1,0,1,1,1,1,1), M_ALL);
    stepClk(4);
    expectOut("R6 no restart while held", mk(8'hC3,1,1,1,0,1,1,1,1,1), M_ALL);
    hostWrN = 1'b1; waitN = 1'b1;
    stepClk(2);
    expectOut("R7 sticky after release", mk(8'hC3,1,1,1,0,1,1,1,1,1), M_CTRL);
    statusRd = 1'b1;
    stepClk(1);
    statusRd = 1'b0;
    expectOut("R7 cleared by status read", mk(8'hC3,1,1,1,0,1,1,1,1,0), M_CTRL);

    // Second timeout, cleared by dedicated input
    hostWrN = 1'b0; hostData = 8'h96;
    stepClk(TO_CYCLES + 1);
    expectOut("R6 second abort", mk(8'h96,1,1,1,0,1,1,1,1,1), M_ALL);
    hostWrN = 1'b1;
    stepClk(1);
    toClr = 1'b1;
    stepClk(1);
    toClr = 1'b0;
    expectOut("R7 cleared by clear input", mk(8'h96,1,1,1,0,1,1,1,1,0), M_CTRL);

    // R8 direction bit back to 1 while idle
    ctlDirBit = 1'b1; ctlStrobe = 1'b0; #1;
    expectOut("R8 direction follows", mk(8'h96,0,1,1,1,1,0,1,1,0), M_CTRL);

    stepClk(2);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule